// File: doc/BRIEF.md
# Credit-Based Transmit Shaper

This block decides, for one transmit queue, whether the queue may start sending. It keeps a signed credit counter. The counter rises while the queue holds data and waits, and falls while the queue transmits. Each rise and fall is clamped to a configured ceiling and floor. The queue is eligible to transmit only while its credit is zero or positive. This is the usual bandwidth reservation scheme for time-sensitive audio and video streams.

The slope and limit inputs are already scaled to the fixed-point units the counter uses. The slopes are scaled by 1024 times a per-speed rate factor over the speed divisor. The limits are scaled by 1024 times 8. All supported link speeds therefore reach the block only through these four numbers. The block performs no scaling arithmetic.

The configuration is captured as one unit on a load strobe. A queue whose identifier parameter is zero can never enter shaped mode. Such a queue, like any queue left unshaped, stays in plain priority mode and is always eligible.

Top module: `cbs_shaper`

## Requirements
- R1: After reset the credit output is 0, the shaped output is 0 and tx_eligible is 1.
- R2: Shaped mode is entered only when a load captures cfg_enable=1 and the QUEUE_ID parameter is not 0. Outside shaped mode the credit is 0 and tx_eligible is 1 on every cycle.
- R3: A cfg_load cycle sets the credit to 0 at the next clock edge. A negative ceiling is stored as 0 and a positive floor is stored as 0. The new mode and limits act from the following cycle on.
- R4: On a tick with q_pending=1 and tx_active=0, the credit rises by the idle slope, limited to the ceiling.
- R5: On a tick with tx_active=1, the credit falls by the send slope, limited to the floor. This applies whatever the value of q_pending.
- R6: On a tick with q_pending=0 and tx_active=0, a positive credit becomes 0. A negative credit rises by the idle slope but does not pass 0.
- R7: In a cycle without tick and without cfg_load, the credit keeps its value.
- R8: In shaped mode, tx_eligible is 1 exactly when the credit is zero or above. It follows the credit update edge with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Capture all configuration inputs this cycle |
| cfg_enable | input | 1 | Requested shaped mode |
| cfg_idle_slope | input | SW | Scaled credit gain per tick while waiting |
| cfg_send_slope | input | SW | Scaled credit loss per tick while sending (magnitude) |
| cfg_hi_credit | input | CW | Scaled credit ceiling, signed |
| cfg_lo_credit | input | CW | Scaled credit floor, signed |
| q_pending | input | 1 | Queue holds data |
| tx_active | input | 1 | Queue is transmitting |
| tick | input | 1 | Credit update strobe |
| credit | output | CW | Current signed credit |
| shaped | output | 1 | Queue is in shaped mode |
| tx_eligible | output | 1 | Queue may start a transmission |

## Verification
On every cycle the assertions check several properties. The credit stays between the stored floor and ceiling. A sending tick never raises the credit, and a waiting tick never lowers it. The credit does not move without a tick or a load. An unshaped queue, including queue 0, sits at zero credit and is eligible. Only the bench scenarios can show the exact step sizes, the points where saturation begins and the recovery of negative credit toward zero on an empty queue. They also show the clamping of limits with the wrong sign and that eligibility switches on the same edge as the credit.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD    = 3'd0,
    ACT_RISE    = 3'd1,
    ACT_FALL    = 3'd2,
    ACT_RECOVER = 3'd3,
    ACT_CLEAR   = 3'd4
  } cbs_act_e;
endpackage

// File: rtl/cbs_rst_sync.sv
module cbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cbs_cfg_bank.sv
module cbs_cfg_bank #(
  parameter int CW       = 32,
  parameter int SW       = 31,
  parameter int QUEUE_ID = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 enable_in,
  input  logic [SW-1:0]        idle_in,
  input  logic [SW-1:0]        send_in,
  input  logic signed [CW-1:0] hi_in,
  input  logic signed [CW-1:0] lo_in,
  output logic [SW-1:0]        idle_q,
  output logic [SW-1:0]        send_q,
  output logic signed [CW-1:0] hi_q,
  output logic signed [CW-1:0] lo_q,
  output logic                 shaped_q
);
  logic                 shaped_d;
  logic signed [CW-1:0] hi_d;
  logic signed [CW-1:0] lo_d;

  generate
    if (QUEUE_ID == 0) begin : g_no_shaper
      assign shaped_d = 1'b0;
    end else begin : g_shaper
      assign shaped_d = enable_in;
    end
  endgenerate

  always_comb begin
    hi_d = hi_in[CW-1] ? '0 : hi_in;
    lo_d = lo_in[CW-1] ? lo_in : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q   <= '0;
      send_q   <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      shaped_q <= 1'b0;
    end else if (load) begin
      idle_q   <= idle_in;
      send_q   <= send_in;
      hi_q     <= hi_d;
      lo_q     <= lo_d;
      shaped_q <= shaped_d;
    end
  end
endmodule

// File: rtl/cbs_action_sel.sv
module cbs_action_sel
  import cbs_pkg::*;
(
  input  logic     load,
  input  logic     shaped,
  input  logic     tick,
  input  logic     pending,
  input  logic     sending,
  output cbs_act_e act
);
  always_comb begin
    if (load || !shaped)  act = ACT_CLEAR;
    else if (!tick)       act = ACT_HOLD;
    else if (sending)     act = ACT_FALL;
    else if (pending)     act = ACT_RISE;
    else                  act = ACT_RECOVER;
  end
endmodule

// File: rtl/cbs_credit_acc.sv
module cbs_credit_acc
  import cbs_pkg::*;
#(
  parameter int CW = 32,
  parameter int SW = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cbs_act_e             act,
  input  logic [SW-1:0]        idle,
  input  logic [SW-1:0]        send,
  input  logic signed [CW-1:0] hi,
  input  logic signed [CW-1:0] lo,
  output logic signed [CW-1:0] credit_q
);
  localparam int XW = CW + 2;

  logic signed [XW-1:0] cur_x, idle_x, send_x, hi_x, lo_x;
  logic signed [XW-1:0] up_x, down_x;
  logic signed [CW-1:0] credit_d;
  logic                 credit_en;

  always_comb begin
    cur_x  = {{2{credit_q[CW-1]}}, credit_q};
    idle_x = {{(XW-SW){1'b0}}, idle};
    send_x = {{(XW-SW){1'b0}}, send};
    hi_x   = {{2{hi[CW-1]}}, hi};
    lo_x   = {{2{lo[CW-1]}}, lo};
    up_x   = cur_x + idle_x;
    down_x = cur_x - send_x;
  end

  always_comb begin
    credit_en = (act != ACT_HOLD);
    credit_d  = credit_q;
    unique case (act)
      ACT_RISE:    credit_d = (up_x > hi_x)   ? hi : up_x[CW-1:0];
      ACT_FALL:    credit_d = (down_x < lo_x) ? lo : down_x[CW-1:0];
      ACT_RECOVER: begin
        if (!credit_q[CW-1])         credit_d = '0;
        else if (up_x > 0)           credit_d = '0;
        else                         credit_d = up_x[CW-1:0];
      end
      ACT_CLEAR:   credit_d = '0;
      default:     credit_d = credit_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         credit_q <= '0;
    else if (credit_en) credit_q <= credit_d;
  end
endmodule

// File: rtl/cbs_shaper.sv
module cbs_shaper
  import cbs_pkg::*;
#(
  parameter int CW       = 32,
  parameter int SW       = CW - 1,
  parameter int QUEUE_ID = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic                 cfg_enable,
  input  logic [SW-1:0]        cfg_idle_slope,
  input  logic [SW-1:0]        cfg_send_slope,
  input  logic signed [CW-1:0] cfg_hi_credit,
  input  logic signed [CW-1:0] cfg_lo_credit,
  input  logic                 q_pending,
  input  logic                 tx_active,
  input  logic                 tick,
  output logic signed [CW-1:0] credit,
  output logic                 shaped,
  output logic                 tx_eligible
);
  logic                 rst_sync_n;
  logic [SW-1:0]        idle_r, send_r;
  logic signed [CW-1:0] hi_r, lo_r;
  cbs_act_e             act;

  cbs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbs_cfg_bank #(.CW(CW), .SW(SW), .QUEUE_ID(QUEUE_ID)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (cfg_load),
    .enable_in (cfg_enable),
    .idle_in   (cfg_idle_slope),
    .send_in   (cfg_send_slope),
    .hi_in     (cfg_hi_credit),
    .lo_in     (cfg_lo_credit),
    .idle_q    (idle_r),
    .send_q    (send_r),
    .hi_q      (hi_r),
    .lo_q      (lo_r),
    .shaped_q  (shaped)
  );

  cbs_action_sel u_sel (
    .load    (cfg_load),
    .shaped  (shaped),
    .tick    (tick),
    .pending (q_pending),
    .sending (tx_active),
    .act     (act)
  );

  cbs_credit_acc #(.CW(CW), .SW(SW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .act      (act),
    .idle     (idle_r),
    .send     (send_r),
    .hi       (hi_r),
    .lo       (lo_r),
    .credit_q (credit)
  );

  assign tx_eligible = !shaped || !credit[CW-1];
endmodule

// File: rtl/cbs_shaper_chk.sv
module cbs_shaper_chk #(
  parameter int CW       = 32,
  parameter int QUEUE_ID = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_load,
  input logic                 tick,
  input logic                 q_pending,
  input logic                 tx_active,
  input logic                 shaped,
  input logic                 tx_eligible,
  input logic signed [CW-1:0] credit,
  input logic signed [CW-1:0] hi_r,
  input logic signed [CW-1:0] lo_r
);
  // R4
  credit_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= hi_r);

  // R5
  credit_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    credit >= lo_r);

  // R5
  send_no_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tx_active && !cfg_load) |=> (credit <= $past(credit)));

  // R4
  wait_no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && q_pending && !tx_active && !cfg_load && shaped) |=> (credit >= $past(credit)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_load && shaped) |=> $stable(credit));

  // R2
  unshaped_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shaped |-> (tx_eligible && credit == '0));

  // R3
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (credit == '0));

  // R2
  always_comb begin
    if (QUEUE_ID == 0) begin
      queue0_unshaped_chk: assert (!shaped || !rst_n);
    end
  end
endmodule

bind cbs_shaper cbs_shaper_chk #(.CW(CW), .QUEUE_ID(QUEUE_ID)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cfg_load    (cfg_load),
  .tick        (tick),
  .q_pending   (q_pending),
  .tx_active   (tx_active),
  .shaped      (shaped),
  .tx_eligible (tx_eligible),
  .credit      (credit),
  .hi_r        (hi_r),
  .lo_r        (lo_r)
);

// File: tb/tb_cbs_shaper.sv
module tb_cbs_shaper;
  localparam int CW = 32;
  localparam int SW = CW - 1;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 cfg_load, cfg_enable, q_pending, tx_active, tick;
  logic [SW-1:0]        cfg_idle_slope, cfg_send_slope;
  logic signed [CW-1:0] cfg_hi_credit, cfg_lo_credit;
  logic signed [CW-1:0] credit, credit0;
  logic                 shaped, tx_eligible, shaped0, tx_eligible0;

  always #5 clk = ~clk;

  cbs_shaper #(.CW(CW), .QUEUE_ID(1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_enable(cfg_enable),
    .cfg_idle_slope(cfg_idle_slope), .cfg_send_slope(cfg_send_slope),
    .cfg_hi_credit(cfg_hi_credit), .cfg_lo_credit(cfg_lo_credit),
    .q_pending(q_pending), .tx_active(tx_active), .tick(tick),
    .credit(credit), .shaped(shaped), .tx_eligible(tx_eligible));

  cbs_shaper #(.CW(CW), .QUEUE_ID(0)) dut_q0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_enable(cfg_enable),
    .cfg_idle_slope(cfg_idle_slope), .cfg_send_slope(cfg_send_slope),
    .cfg_hi_credit(cfg_hi_credit), .cfg_lo_credit(cfg_lo_credit),
    .q_pending(q_pending), .tx_active(tx_active), .tick(tick),
    .credit(credit0), .shaped(shaped0), .tx_eligible(tx_eligible0));

  typedef struct {
    longint cr;
    bit     sh;
    bit     el;
    string  tag;
  } exp_t;

  exp_t   exp_q[$];
  int     n_checks = 0;
  int     n_errors = 0;
  longint m_credit = 0, m_hi = 0, m_lo = 0, m_idle = 0, m_send = 0;
  bit     m_shaped = 0;

  task automatic check(bit ok, string tag, string act, string expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%s expected=%s", tag, act, expv);
    end
  endtask

  task automatic step(bit ld, bit tk, bit pd, bit tx, string tag);
    exp_t e;
    @(negedge clk);
    cfg_load = ld; tick = tk; q_pending = pd; tx_active = tx;
    if (ld || !m_shaped) m_credit = 0;
    else if (tk) begin
      if (tx) begin
        m_credit = m_credit - m_send;
        if (m_credit < m_lo) m_credit = m_lo;
      end else if (pd) begin
        m_credit = m_credit + m_idle;
        if (m_credit > m_hi) m_credit = m_hi;
      end else if (m_credit > 0) m_credit = 0;
      else begin
        m_credit = m_credit + m_idle;
        if (m_credit > 0) m_credit = 0;
      end
    end
    if (ld) begin
      m_shaped = cfg_enable;
      m_hi     = (cfg_hi_credit < 0) ? 0 : longint'(cfg_hi_credit);
      m_lo     = (cfg_lo_credit > 0) ? 0 : longint'(cfg_lo_credit);
      m_idle   = longint'(cfg_idle_slope);
      m_send   = longint'(cfg_send_slope);
    end
    e.cr = m_credit; e.sh = m_shaped; e.el = !m_shaped || (m_credit >= 0); e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic load(bit en, int idle, int snd, int hi, int lo, string tag);
    cfg_enable = en; cfg_idle_slope = SW'(idle); cfg_send_slope = SW'(snd);
    cfg_hi_credit = CW'(hi); cfg_lo_credit = CW'(lo);
    step(1'b1, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(longint'(credit) == e.cr && shaped == e.sh && tx_eligible == e.el, e.tag,
              $sformatf("cr=%0d sh=%0b el=%0b", credit, shaped, tx_eligible),
              $sformatf("cr=%0d sh=%0b el=%0b", e.cr, e.sh, e.el));
        // R2: queue 0 never shaped
        check(credit0 == 0 && !shaped0 && tx_eligible0, "R2 queue0",
              $sformatf("cr=%0d sh=%0b el=%0b", credit0, shaped0, tx_eligible0),
              "cr=0 sh=0 el=1");
      end
    end
  end

  initial begin : watchdog
    #2_000_000;
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0; cfg_load = 0; cfg_enable = 0; q_pending = 0; tx_active = 0; tick = 0;
    cfg_idle_slope = '0; cfg_send_slope = '0; cfg_hi_credit = '0; cfg_lo_credit = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(credit == 0 && !shaped && tx_eligible, "R1 reset",
          $sformatf("cr=%0d sh=%0b el=%0b", credit, shaped, tx_eligible), "cr=0 sh=0 el=1");
    // R2: unshaped ignores ticks while sending
    step(0, 1, 1, 1, "R2 unshaped tx");
    load(1, 300, 700, 1000, -1400, "R3 load");
    // R4: rise and saturate
    for (int i = 0; i < 5; i++) step(0, 1, 1, 0, "R4 rise");
    // R7: no tick keeps value
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R7 hold");
    // R5 and R8: fall through zero, eligibility drops, saturate
    for (int i = 0; i < 6; i++) step(0, 1, 1, 1, "R5 R8 fall");
    step(0, 0, 0, 1, "R7 hold tx");
    // R6: recover negative toward zero
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, "R6 recover");
    step(0, 1, 1, 0, "R4 rise");
    step(0, 1, 0, 0, "R6 positive to zero");
    // R5: sending wins over pending, only pending=0 here too
    step(0, 1, 0, 1, "R5 tx empty");
    step(0, 1, 1, 0, "R4 rise");
    // R3: reload clears credit, bad-sign limits clamp
    load(1, 50, 60, -5, 7, "R3 reload");
    step(0, 1, 1, 0, "R3 hi clamp");
    step(0, 1, 0, 1, "R3 lo clamp");
    // R2: disable returns to priority mode
    load(1, 300, 700, 1000, -1400, "R3 load");
    step(0, 1, 0, 1, "R8 neg");
    load(0, 300, 700, 1000, -1400, "R2 disable");
    step(0, 1, 0, 1, "R2 unshaped");
    step(0, 0, 0, 0, "R2 idle");
    step(0, 0, 0, 0, "R2 idle");
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule